// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Aggregator

This block folds seventeen serial interrupt lines, a link-reset event and eight bus-cycle error/request events into a single interrupt level. It does this through two register banks reached over a flat 32-bit register port with a byte offset. The first bank is the host-side bank. Each serial line latches a sticky status bit on its rising edge, and each event latches one while it is high. A mask and a global enable turn the masked status into one internal request.

The second bank is the bus-master bank. Its read-only input register shows that request live in one fixed bit. Each cycle, a sticky status register gathers the input ANDed with a mask. The block's output stays high for as long as that status is nonzero. Software clears both status registers by writing ones. Reads are combinational and have no side effects. The block does not decode serial-interrupt frames or generate error events: these arrive as plain inputs.

Top module: `irq_cascade_agg`

## Requirements
- R1: A rising edge on serial line n (n = 0..16) sets host status bit 31-n one clock later. A line that is held high does not set the bit again after software clears it.
- R2: Host status bits are sticky. A serial line that returns low leaves its bit set.
- R3: Writing the host status register (offset 0x38) clears each bit that is written as one and leaves the other bits unchanged.
- R4: The first-stage request is active only while control bit 31 (offset 0x30) is set and host status AND host mask (offset 0x34) is nonzero.
- R5: Bit 11 of the read-only input register (offset 0x5C) shows the first-stage request live. Its other bits read zero, and writes to it are ignored.
- R6: On every clock, the bus-master status (offset 0x50) ORs in input AND bus-master mask (offset 0x54). The output is high while that status is nonzero, so a mask write reaches the output one clock after it takes effect.
- R7: The polarity register (offset 0x58) reads back what was written and has no effect on the output.
- R8: A read from any offset outside 0x24, 0x28, 0x30, 0x34, 0x38, 0x40, 0x50, 0x54, 0x58 and 0x5C returns 0xFFFFFFFF.
- R9: After reset the read-size register (offset 0x28) reads 0x02000000. It and the segment-select register (offset 0x24) store whole words. The error-address register (offset 0x40) reads zero and ignores writes.
- R10: When a status bit is set and cleared in the same cycle, the set wins, in both banks.
- R11: A high link-reset event sets host status bit 10, and a high on bus event k (k = 0..7) sets host status bit k.
- R12: Writing ones to bus-master status clears them once the masked input is low, and the output then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| serirq_in | input | 17 | Serial interrupt levels, line n at index n |
| lreset_evt | input | 1 | Link reset event |
| bus_evt | input | 8 | Bus-cycle error and request events |
| irq_out | output | 1 | Aggregated interrupt level |

## Verification
Two functions can land on the same clock edge: a write-one-to-clear and a new hardware setting of the same status bit. The bench provokes this in two ways. In the host bank, a serial line rises in the very cycle that software writes a one to clear its bit. In the bus-master bank, software clears the status while the masked first-stage request is still active. In both cases the status is read back afterwards, and the bit must still be set. A later clear, made once the source is quiet, must then succeed and drop the output.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

    parameter int DATA_W      = 32;
    parameter int ADDR_W      = 8;
    parameter int NUM_SERIAL  = 17;
    parameter int NUM_BUS_EVT = 8;

    localparam int SERIAL_TOP  = DATA_W - 1;
    localparam int LRESET_BIT  = 10;
    localparam int CTRL_EN_BIT = 31;
    localparam int CASCADE_BIT = 11;

    localparam logic [DATA_W-1:0] ACCSZ_RESET = 32'h0200_0000;

    localparam logic [ADDR_W-1:0] OFF_IDSEL  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_ACCSZ  = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_HMASK  = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_HSTAT  = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_ERRADR = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_BSTAT  = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_BMASK  = 8'h54;
    localparam logic [ADDR_W-1:0] OFF_BPOL   = 8'h58;
    localparam logic [ADDR_W-1:0] OFF_BIN    = 8'h5C;

    typedef enum logic [3:0] {
        SEL_IDSEL, SEL_ACCSZ, SEL_CTRL, SEL_HMASK, SEL_HSTAT,
        SEL_ERRADR, SEL_BSTAT, SEL_BMASK, SEL_BPOL, SEL_BIN, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } reg_req_t;

    function automatic reg_sel_e decode_off(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_IDSEL:  return SEL_IDSEL;
            OFF_ACCSZ:  return SEL_ACCSZ;
            OFF_CTRL:   return SEL_CTRL;
            OFF_HMASK:  return SEL_HMASK;
            OFF_HSTAT:  return SEL_HSTAT;
            OFF_ERRADR: return SEL_ERRADR;
            OFF_BSTAT:  return SEL_BSTAT;
            OFF_BMASK:  return SEL_BMASK;
            OFF_BPOL:   return SEL_BPOL;
            OFF_BIN:    return SEL_BIN;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        return decode_off(a) != SEL_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] w1c_mask(input reg_req_t r, input reg_sel_e s);
        return (r.wr && r.sel == s) ? r.data : '0;
    endfunction

endpackage

// File: rtl/irq_hc_stage.sv
module irq_hc_stage
    import irq_cascade_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  reg_req_t               req,
    input  logic [NUM_SERIAL-1:0]  serirq_in,
    input  logic                   lreset_evt,
    input  logic [NUM_BUS_EVT-1:0] bus_evt,
    output logic [DATA_W-1:0]      idsel_q,
    output logic [DATA_W-1:0]      accsz_q,
    output logic [DATA_W-1:0]      ctrl_q,
    output logic [DATA_W-1:0]      mask_q,
    output logic [DATA_W-1:0]      status_q,
    output logic                   active
);

    logic [NUM_SERIAL-1:0] ser_prev_q;
    logic [NUM_SERIAL-1:0] ser_rise;
    logic [DATA_W-1:0]     set_vec;
    logic [DATA_W-1:0]     ser_vec;
    logic [DATA_W-1:0]     evt_vec;

    assign ser_rise = serirq_in & ~ser_prev_q;

    for (genvar n = 0; n < NUM_SERIAL; n++) begin : g_ser_map
        assign ser_vec[SERIAL_TOP-n] = ser_rise[n];
    end
    for (genvar b = 0; b < DATA_W - NUM_SERIAL; b++) begin : g_ser_zero
        assign ser_vec[b] = 1'b0;
    end

    always_comb begin
        evt_vec                    = '0;
        evt_vec[NUM_BUS_EVT-1:0]   = bus_evt;
        evt_vec[LRESET_BIT]        = lreset_evt;
    end

    assign set_vec = ser_vec | evt_vec;
    assign active  = ctrl_q[CTRL_EN_BIT] && ((status_q & mask_q) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_prev_q <= '0;
            idsel_q    <= '0;
            accsz_q    <= ACCSZ_RESET;
            ctrl_q     <= '0;
            mask_q     <= '0;
            status_q   <= '0;
        end else begin
            ser_prev_q <= serirq_in;
            if (req.wr && req.sel == SEL_IDSEL) idsel_q <= req.data;
            if (req.wr && req.sel == SEL_ACCSZ) accsz_q <= req.data;
            if (req.wr && req.sel == SEL_CTRL)  ctrl_q  <= req.data;
            if (req.wr && req.sel == SEL_HMASK) mask_q  <= req.data;
            status_q <= (status_q & ~w1c_mask(req, SEL_HSTAT)) | set_vec;
        end
    end

endmodule

// File: rtl/irq_bm_stage.sv
module irq_bm_stage
    import irq_cascade_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic              hc_active,
    output logic [DATA_W-1:0] input_vec,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] pol_q,
    output logic              irq
);

    always_comb begin
        input_vec              = '0;
        input_vec[CASCADE_BIT] = hc_active;
    end

    assign irq = status_q != '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
            pol_q    <= '0;
        end else begin
            if (req.wr && req.sel == SEL_BMASK) mask_q <= req.data;
            if (req.wr && req.sel == SEL_BPOL)  pol_q  <= req.data;
            status_q <= (status_q & ~w1c_mask(req, SEL_BSTAT)) | (input_vec & mask_q);
        end
    end

endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
    import irq_cascade_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic                   reg_wr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic [NUM_SERIAL-1:0]  serirq_in,
    input  logic                   lreset_evt,
    input  logic [NUM_BUS_EVT-1:0] bus_evt,
    output logic                   irq_out
);

    reg_req_t          req;
    reg_sel_e          rd_sel;
    logic [DATA_W-1:0] idsel_q, accsz_q, ctrl_q, hc_mask_q, hc_status;
    logic              hc_active;
    logic [DATA_W-1:0] bm_input, bm_status, bm_mask_q, bm_pol_q;

    assign rd_sel   = decode_off(reg_addr);
    assign req.wr   = reg_wr;
    assign req.sel  = rd_sel;
    assign req.data = reg_wdata;

    irq_hc_stage u_hc (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .serirq_in  (serirq_in),
        .lreset_evt (lreset_evt),
        .bus_evt    (bus_evt),
        .idsel_q    (idsel_q),
        .accsz_q    (accsz_q),
        .ctrl_q     (ctrl_q),
        .mask_q     (hc_mask_q),
        .status_q   (hc_status),
        .active     (hc_active)
    );

    irq_bm_stage u_bm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .hc_active (hc_active),
        .input_vec (bm_input),
        .status_q  (bm_status),
        .mask_q    (bm_mask_q),
        .pol_q     (bm_pol_q),
        .irq       (irq_out)
    );

    always_comb begin
        case (rd_sel)
            SEL_IDSEL:  reg_rdata = idsel_q;
            SEL_ACCSZ:  reg_rdata = accsz_q;
            SEL_CTRL:   reg_rdata = ctrl_q;
            SEL_HMASK:  reg_rdata = hc_mask_q;
            SEL_HSTAT:  reg_rdata = hc_status;
            SEL_ERRADR: reg_rdata = '0;
            SEL_BSTAT:  reg_rdata = bm_status;
            SEL_BMASK:  reg_rdata = bm_mask_q;
            SEL_BPOL:   reg_rdata = bm_pol_q;
            SEL_BIN:    reg_rdata = bm_input;
            default:    reg_rdata = '1;
        endcase
    end

endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
    import irq_cascade_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic                  reg_wr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic [DATA_W-1:0]     reg_rdata,
    input logic [NUM_SERIAL-1:0] serirq_in,
    input logic                  irq_out,
    input logic [DATA_W-1:0]     hc_status,
    input logic                  hc_active,
    input logic [DATA_W-1:0]     bm_mask_q
);

    p_serial_latch_r1: assert property (@(posedge clk) disable iff (rst)
        (serirq_in[0] && !$past(serirq_in[0])) |=> hc_status[SERIAL_TOP]);

    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (hc_status[SERIAL_TOP] && !(reg_wr && reg_addr == OFF_HSTAT && reg_wdata[SERIAL_TOP]))
        |=> hc_status[SERIAL_TOP]);

    p_cascade_r6: assert property (@(posedge clk) disable iff (rst)
        (hc_active && bm_mask_q[CASCADE_BIT]) |=> irq_out);

    p_out_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !(reg_wr && reg_addr == OFF_BSTAT)) |=> irq_out);

    p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
        !is_mapped(reg_addr) |-> (reg_rdata == '1));

endmodule

bind irq_cascade_agg irq_cascade_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .serirq_in (serirq_in),
    .irq_out   (irq_out),
    .hc_status (hc_status),
    .hc_active (hc_active),
    .bm_mask_q (bm_mask_q)
);

// File: tb/tb_irq_cascade_agg.sv
module tb_irq_cascade_agg;
    import irq_cascade_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [ADDR_W-1:0]      reg_addr = '0;
    logic                   reg_wr = 1'b0;
    logic [DATA_W-1:0]      reg_wdata = '0;
    logic [DATA_W-1:0]      reg_rdata;
    logic [NUM_SERIAL-1:0]  serirq_in = '0;
    logic                   lreset_evt = 1'b0;
    logic [NUM_BUS_EVT-1:0] bus_evt = '0;
    logic                   irq_out;

    always #10 clk = ~clk;

    irq_cascade_agg dut (.*);

    typedef struct {
        bit          pin;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    // monitor: compares queued expectations well after the falling edge
    always begin
        @(negedge clk);
        #5;
        while (q.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.pin ? {31'b0, irq_out} : reg_rdata;
            n_vec++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic exp_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        q.push_back('{1'b0, e, tag});
    endtask

    task automatic exp_pin(input logic e, input string tag);
        @(negedge clk);
        q.push_back('{1'b1, {31'b0, e}, tag});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        exp_reg(OFF_ACCSZ, 32'h0200_0000, "R9 read size reset");
        exp_reg(OFF_HSTAT, 32'h0, "R1 host status reset");
        exp_pin(1'b0, "R6 output reset");
        exp_reg(8'h00, 32'hFFFF_FFFF, "R8 unmapped 0x00");
        exp_reg(8'h44, 32'hFFFF_FFFF, "R8 unmapped 0x44");
        exp_reg(8'h5D, 32'hFFFF_FFFF, "R8 unmapped 0x5D");

        // serial latching, reverse order, stickiness
        @(negedge clk); serirq_in[0] = 1'b1;
        exp_reg(OFF_HSTAT, 32'h8000_0000, "R1 line0 -> bit31");
        @(negedge clk); serirq_in[0] = 1'b0;
        exp_reg(OFF_HSTAT, 32'h8000_0000, "R2 line0 low keeps bit");
        @(negedge clk); serirq_in[16] = 1'b1;
        exp_reg(OFF_HSTAT, 32'h8000_8000, "R1 line16 -> bit15");
        @(negedge clk); serirq_in[16] = 1'b0;

        // enable off: no request
        wr(OFF_HMASK, 32'h8000_0000);
        exp_reg(OFF_BIN, 32'h0, "R4 disabled gives no request");
        wr(OFF_CTRL, 32'h8000_0000);
        exp_reg(OFF_BIN, 32'h0000_0800, "R5 request mirrored at bit11");
        exp_pin(1'b0, "R6 bus-master mask zero keeps output low");

        // mask write latency
        wr(OFF_BMASK, 32'h0000_0800);
        exp_pin(1'b0, "R6 output one clock after mask write");
        exp_pin(1'b1, "R6 output high");
        exp_reg(OFF_BSTAT, 32'h0000_0800, "R6 bus-master status");

        // polarity and read-only input
        wr(OFF_BPOL, 32'h1234_5678);
        exp_reg(OFF_BPOL, 32'h1234_5678, "R7 polarity readback");
        exp_pin(1'b1, "R7 polarity no effect");
        wr(OFF_BIN, 32'hFFFF_FFFF);
        exp_reg(OFF_BIN, 32'h0000_0800, "R5 input write ignored");

        // plain storage / error address
        wr(OFF_IDSEL, 32'hA5A5_0F0F);
        exp_reg(OFF_IDSEL, 32'hA5A5_0F0F, "R9 segment select storage");
        wr(OFF_ERRADR, 32'hDEAD_BEEF);
        exp_reg(OFF_ERRADR, 32'h0, "R9 error address ignores write");

        // same-cycle clear and set in second bank
        wr(OFF_BSTAT, 32'h0000_0800);
        exp_reg(OFF_BSTAT, 32'h0000_0800, "R10 bus-master set beats clear");

        // W1C host status, partial
        wr(OFF_HSTAT, 32'h8000_0000);
        exp_reg(OFF_HSTAT, 32'h0000_8000, "R3 clear only written ones");
        exp_reg(OFF_BIN, 32'h0, "R4 request drops after clear");
        wr(OFF_BSTAT, 32'h0000_0800);
        exp_reg(OFF_BSTAT, 32'h0, "R12 bus-master clear");
        exp_pin(1'b0, "R12 output falls");

        // same-cycle clear and rising edge in host bank
        @(negedge clk);
        serirq_in[1] = 1'b1;
        reg_addr     = OFF_HSTAT;
        reg_wdata    = 32'h4000_0000;
        reg_wr       = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
        exp_reg(OFF_HSTAT, 32'h4000_8000, "R10 host set beats clear");

        // events
        @(negedge clk); lreset_evt = 1'b1; bus_evt = 8'h08;
        @(negedge clk); lreset_evt = 1'b0; bus_evt = 8'h00;
        exp_reg(OFF_HSTAT, 32'h4000_8408, "R11 link reset bit10, event bit3");

        // held line not re-latched
        wr(OFF_HSTAT, 32'hFFFF_FFFF);
        exp_reg(OFF_HSTAT, 32'h0, "R1 held line does not re-set");
        exp_pin(1'b0, "R6 output stays low");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule